// File: doc/BRIEF.md
# Calibrated One-Second Prescaler

This block turns a 32768 Hz clock-enable into a one-cycle pulse per second. A fixed count of enables makes up each second. A signed 5-bit trim value nudges that count so the long-term rate can be tuned against crystal error. The trim acts only at the boundary of the 256-enable stage of the divider. It is spread over a 64-minute cycle, with at most one altered second per minute. The minute count is driven from outside through a minute-boundary strobe.

The block also drives an open-drain output level. In test mode the level toggles at 512 Hz, taken straight from the raw enable, so a bench counter can measure crystal error whatever trim is loaded. Outside test mode the level is a static bit from the control byte. A stop input clears the divider and holds it.

Top module: `cal_prescaler`

## Requirements
- R1: While reset is asserted, `tick_o` is 0 and `pin_low_o` is 0 (pin released). The control byte holds its reset value, which has the output-level bit set and the test bit cleared, whatever `ctrl_i` carries.
- R2: With no trim due, each second lasts 2^DIV_W enables. `tick_o` pulses for exactly one cycle, in the cycle after the enable that completes the second.
- R3: Cycles with `osc_en_i` low do not advance the divider. A second with gaps lasts 2^DIV_W enables, however many idle cycles lie between them.
- R4: Control byte encoding: bit 7 is the output level, bit 6 is test mode, bit 5 is the sign (1 = positive, speeds up) and bits 4:0 are the magnitude. A positive adjusted second is 256 enables shorter than nominal.
- R5: A negative adjusted second is 128 enables longer than nominal.
- R6: The minute index counts `minute_i` pulses modulo 64 and starts at 0 after reset. A magnitude N adjusts one second in each of the minutes 0 to 2N-1 of the cycle. The adjustment lands on the second in progress when that minute starts.
- R7: The sign and magnitude are taken from the control byte only on the `minute_i` pulse that wraps the index from 63 to 0. Changes made in the middle of a cycle have no effect until the next wrap.
- R8: With magnitude 31, minute 61 is still adjusted and minute 62 is not.
- R9: While `stop_i` is high the divider is cleared and `tick_o` stays 0. After release, the first tick comes after a full 2^DIV_W enables.
- R10: With test mode set, `pin_low_o` toggles every TEST_HALF (32) enables. This holds while a trim is being applied.
- R11: With test mode clear, `pin_low_o` is the inverse of the output-level bit and follows `ctrl_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One enable per 32768 Hz oscillator period |
| ctrl_i | input | 8 | Control byte: level, test, sign, magnitude |
| stop_i | input | 1 | Clear and hold the divider |
| minute_i | input | 1 | Minute-boundary strobe, one per cycle high |
| tick_o | output | 1 | One-cycle pulse per second |
| pin_low_o | output | 1 | 1 = drive the open-drain pin low, 0 = release |

## Verification
A tick is due in the cycle after the enable that completes its second, so the length of a second is measured in whole cycles between two tick samples. The bench samples on the falling edge and holds the enable high, so each interval equals the enable count the requirement predicts. The scoreboard queues 2^DIV_W, minus 256 for a positive step, plus 128 for a negative one, plus any idle gap. The output pin is checked one cycle after `ctrl_i` changes. In test mode it is checked over consecutive 32-cycle half periods. After `stop_i` is released, the first tick is counted to the exact cycle.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;
  localparam int CAL_MAG_W = 5;

  typedef struct packed {
    logic                 out_lvl;
    logic                 ft;
    logic                 sign;
    logic [CAL_MAG_W-1:0] mag;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{out_lvl: 1'b1, ft: 1'b0, sign: 1'b0, mag: '0};
endpackage

// File: rtl/cal_sched.sv
module cal_sched
  import cal_prescaler_pkg::*;
#(
  parameter int MIN_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 minute_i,
  input  logic                 cal_sign_i,
  input  logic [CAL_MAG_W-1:0] cal_mag_i,
  input  logic                 apply_i,
  output logic                 pend_pos_o,
  output logic                 pend_neg_o
);
  localparam int CMP_W = ((MIN_W > CAL_MAG_W + 1) ? MIN_W : CAL_MAG_W + 1) + 1;

  logic [MIN_W-1:0]     idx_q, idx_nxt;
  logic [CAL_MAG_W-1:0] mag_q, mag_sel;
  logic                 sign_q, sign_sel;
  logic                 pend_q, pend_sign_q;
  logic                 cycle_start, adj_hit;

  always_comb begin
    idx_nxt     = idx_q + 1'b1;
    cycle_start = (idx_nxt == '0);
    mag_sel     = cycle_start ? cal_mag_i  : mag_q;
    sign_sel    = cycle_start ? cal_sign_i : sign_q;
    // minute k is adjusted when k < 2N
    adj_hit     = CMP_W'(idx_nxt) < CMP_W'({mag_sel, 1'b0});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      mag_q       <= '0;
      sign_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_sign_q <= 1'b0;
    end else if (minute_i) begin
      idx_q       <= idx_nxt;
      pend_q      <= adj_hit;
      pend_sign_q <= sign_sel;
      if (cycle_start) begin
        mag_q  <= cal_mag_i;
        sign_q <= cal_sign_i;
      end
    end else if (apply_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_pos_o = pend_q & pend_sign_q;
  assign pend_neg_o = pend_q & ~pend_sign_q;

  assert_cal_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(minute_i && idx_q == '1) |=> ($stable(mag_q) && $stable(sign_q)));
endmodule

// File: rtl/prescaler_div.sv
module prescaler_div #(
  parameter int DIV_W   = 15,
  parameter int STAGE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic stop_i,
  input  logic pend_pos_i,
  input  logic pend_neg_i,
  output logic apply_o,
  output logic tick_o
);
  localparam int HI_W   = DIV_W - STAGE_W;
  localparam int HOLD_W = STAGE_W - 1;
  localparam logic [HI_W:0] INC_ONE = 1;
  localparam logic [HI_W:0] INC_TWO = 2;

  logic [STAGE_W-1:0] lo_q;
  logic [HI_W-1:0]    hi_q;
  logic [HOLD_W-1:0]  hold_cnt_q;
  logic               hold_act_q, tick_q;
  logic               carry, wrap;
  logic [HI_W:0]      sum;

  always_comb begin
    carry   = osc_en_i && !stop_i && !hold_act_q && (lo_q == '1);
    apply_o = carry && (pend_pos_i || pend_neg_i);
    // positive step: upper stage jumps by two, dropping 2^STAGE_W enables
    sum     = {1'b0, hi_q} + ((apply_o && pend_pos_i) ? INC_TWO : INC_ONE);
    wrap    = carry && sum[HI_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q       <= '0;
      hi_q       <= '0;
      hold_cnt_q <= '0;
      hold_act_q <= 1'b0;
      tick_q     <= 1'b0;
    end else if (stop_i) begin
      lo_q       <= '0;
      hi_q       <= '0;
      hold_cnt_q <= '0;
      hold_act_q <= 1'b0;
      tick_q     <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (osc_en_i) begin
        if (hold_act_q) begin
          hold_cnt_q <= hold_cnt_q + 1'b1;
          if (hold_cnt_q == '1) hold_act_q <= 1'b0;
        end else begin
          lo_q <= lo_q + 1'b1;
          if (carry) begin
            hi_q <= sum[HI_W-1:0];
            // negative step: freeze for half a stage
            if (apply_o && pend_neg_i) begin
              hold_act_q <= 1'b1;
              hold_cnt_q <= '0;
            end
          end
        end
      end
    end
  end

  assign tick_o = tick_q;

  assert_tick_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_i && !stop_i) |=> ($stable(lo_q) && $stable(hi_q)));
  assert_hold_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act_q && !stop_i) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/test_toggle.sv
module test_toggle #(
  parameter int TEST_HALF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic stop_i,
  output logic tog_o
);
  localparam int CNT_W = (TEST_HALF > 1) ? $clog2(TEST_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TEST_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (osc_en_i && !stop_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        tog_q <= ~tog_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tog_o = tog_q;

  assert_test_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(tog_q));
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_prescaler_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int STAGE_W   = 8,
  parameter int MIN_W     = 6,
  parameter int TEST_HALF = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic [7:0] ctrl_i,
  input  logic       stop_i,
  input  logic       minute_i,
  output logic       tick_o,
  output logic       pin_low_o
);
  ctrl_t ctrl_q;
  logic  pend_pos, pend_neg, apply, tog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_t'(ctrl_i);
  end

  cal_sched #(.MIN_W(MIN_W)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .minute_i   (minute_i),
    .cal_sign_i (ctrl_q.sign),
    .cal_mag_i  (ctrl_q.mag),
    .apply_i    (apply),
    .pend_pos_o (pend_pos),
    .pend_neg_o (pend_neg)
  );

  prescaler_div #(.DIV_W(DIV_W), .STAGE_W(STAGE_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_en_i   (osc_en_i),
    .stop_i     (stop_i),
    .pend_pos_i (pend_pos),
    .pend_neg_i (pend_neg),
    .apply_o    (apply),
    .tick_o     (tick_o)
  );

  test_toggle #(.TEST_HALF(TEST_HALF)) u_test (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_en_i (osc_en_i),
    .stop_i   (stop_i),
    .tog_o    (tog)
  );

  assign pin_low_o = ctrl_q.ft ? tog : ~ctrl_q.out_lvl;

  assert_stop_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !tick_o);
  assert_out_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[6] |=> (pin_low_o == !$past(ctrl_i[7])));
endmodule

// File: tb/cal_prescaler_tb_top.sv
module cal_prescaler_tb_top;
  localparam int SEC = 1024;

  logic       clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, stop = 1'b0, minute = 1'b0;
  logic [7:0] ctrl = 8'h40;
  logic       tick, pin_low;
  int         n_checks = 0, n_errs = 0;
  bit         mon_on = 1'b0;

  typedef struct {
    int    exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  cal_prescaler #(.DIV_W(10)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .osc_en_i  (osc_en),
    .ctrl_i    (ctrl),
    .stop_i    (stop),
    .minute_i  (minute),
    .tick_o    (tick),
    .pin_low_o (pin_low)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int e, string t);
    exp_t x;
    x.exp = e;
    x.tag = t;
    sb_q.push_back(x);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic pulse_min(int n);
    minute = 1'b1;
    repeat (n) @(negedge clk);
    minute = 1'b0;
  endtask

  // monitor: interval between ticks in cycles, compared against the queue
  initial begin
    int   cyc, last;
    bit   have;
    exp_t e;
    cyc = 0; last = 0; have = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!mon_on) have = 1'b0;
      else if (tick) begin
        if (have) begin
          if (sb_q.size() == 0) check(1'b0, "R2 unexpected tick", cyc - last, 0);
          else begin
            e = sb_q.pop_front();
            check((cyc - last) == e.exp, e.tag, cyc - last, e.exp);
          end
        end
        last = cyc;
        have = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int  c, lc, seen, nt;
    logic prev;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(pin_low == 1'b0, "R1 pin released in reset", int'(pin_low), 0);
    ctrl = 8'h80; osc_en = 1'b1; rst_n = 1'b1; mon_on = 1'b1;

    // nominal seconds
    repeat (3) push(SEC, "R2 nominal second");
    repeat (4) wait_tick();

    // positive, magnitude 2: minutes 0..3 adjusted
    ctrl = 8'hA2;
    push(SEC - 256, "R4 positive step minute 0"); pulse_min(64); wait_tick();
    push(SEC - 256, "R6 minute 1 adjusted");      pulse_min(1);  wait_tick();
    ctrl = 8'h80;
    push(SEC - 256, "R7 mid-cycle change ignored"); pulse_min(1); wait_tick();
    push(SEC - 256, "R6 minute 3 adjusted");      pulse_min(1);  wait_tick();
    push(SEC, "R6 minute 4 not adjusted");        pulse_min(1);  wait_tick();

    // negative, magnitude 1: minutes 0..1
    ctrl = 8'h81;
    push(SEC + 128, "R5 negative step minute 0"); pulse_min(60); wait_tick();
    push(SEC + 128, "R5 negative step minute 1"); pulse_min(1);  wait_tick();
    push(SEC, "R6 minute 2 not adjusted");        pulse_min(1);  wait_tick();

    // positive, magnitude 31
    ctrl = 8'hBF;
    push(SEC - 256, "R8 mag 31 minute 0");        pulse_min(62); wait_tick();
    push(SEC - 256, "R8 one step per minute");    pulse_min(60); wait_tick();
    push(SEC - 256, "R8 minute 61 adjusted");     pulse_min(1);  wait_tick();
    push(SEC, "R8 minute 62 not adjusted");       pulse_min(1);  wait_tick();

    // idle enables
    osc_en = 1'b0;
    push(SEC + 3000, "R3 idle cycles do not count");
    repeat (3000) @(negedge clk);
    osc_en = 1'b1;
    wait_tick();

    // test mode during an adjusted second
    ctrl = 8'hFF;
    push(SEC - 256, "R10 trim still applied");
    pulse_min(2);
    prev = pin_low; c = 0; lc = -1; seen = 0;
    while (seen < 17) begin
      @(negedge clk);
      c++;
      if (pin_low != prev) begin
        prev = pin_low;
        if (lc >= 0) check((c - lc) == 32, "R10 test half period", c - lc, 32);
        lc = c;
        seen++;
      end
    end
    wait_tick();

    // static output level
    mon_on = 1'b0;
    ctrl = 8'h3F;
    @(negedge clk);
    check(pin_low == 1'b1, "R11 level 0 drives low", int'(pin_low), 1);
    ctrl = 8'hBF;
    @(negedge clk);
    check(pin_low == 1'b0, "R11 level 1 releases", int'(pin_low), 0);

    // stop
    stop = 1'b1; nt = 0;
    repeat (2000) begin
      @(negedge clk);
      if (tick) nt++;
    end
    check(nt == 0, "R9 no tick while stopped", nt, 0);
    stop = 1'b0; c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tick && c < 5000);
    check(c == SEC, "R9 full second after release", c, SEC);

    check(sb_q.size() == 0, "R2 all expected ticks seen", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule